// File: doc/BRIEF.md
# Burst-Limited Target Handshake Controller

This block is the target-side handshake engine of a simple slave on a parallel shared bus of the PCI family. It watches the initiator's cycle-active and initiator-ready lines, plus a decode-hit flag supplied by the address logic. From these it drives the target-select, target-ready and stop lines, and it pulses an internal strobe for every word that crosses the bus. All bus lines are active-low. A line is asserted when it is 0.

The slave takes no more than `BURST_MAX` words in one transaction. When the initiator wants more, the target raises its stop line together with target-ready on the final word it accepts, so that word is still transferred. After that word, target-ready stays off. Stop and select stay on until the initiator has let go of both of its lines, which allows the initiator to spend one extra clock in a final phase that completes on stop alone. A burst that the initiator ends early finishes normally with no stop. A transaction claimed by another target is tracked until the bus is idle, and it is never claimed part-way through.

Top module: `burst_target_ctrl`

## Requirements
- R1: While `rst_n` is sampled low, `tgt_sel_n`, `tgt_rdy_n` and `tgt_halt_n` are 1 on the following clock, and `word_strobe` is 0.
- R2: If the block is idle and samples `ini_cyc_n`=0 with `addr_hit`=1, it drives `tgt_sel_n`=0 and `tgt_rdy_n`=0 from the next clock.
- R3: If the block is idle and samples `ini_cyc_n`=0 with `addr_hit`=0, it keeps `tgt_sel_n` and `tgt_rdy_n` at 1 for the whole of that transaction, even if `addr_hit` rises later. It becomes idle again only after sampling `ini_cyc_n`=1 and `ini_rdy_n`=1.
- R4: `word_strobe` is 1 exactly on the clocks where `ini_rdy_n`=0 and `tgt_rdy_n`=0. Each transferred word therefore gives one pulse.
- R5: A transaction transfers at most `BURST_MAX` words. If the initiator is still holding `ini_cyc_n`=0 when word `BURST_MAX`-1 completes, `tgt_halt_n` goes to 0 together with `tgt_rdy_n`=0 for word `BURST_MAX`. When `BURST_MAX`=1, this happens at the claim.
- R6: After a phase that completes with `tgt_rdy_n`=0 and `tgt_halt_n`=0, `tgt_rdy_n` is 1 on the next clock and stays 1 until the transaction ends.
- R7: Once `tgt_halt_n` is 0, it stays 0 until the block samples `ini_cyc_n`=1 and `ini_rdy_n`=1. On the next clock, `tgt_halt_n` and `tgt_sel_n` both return to 1.
- R8: If a word completes with `ini_cyc_n`=1 and no stop is asserted, `tgt_sel_n` and `tgt_rdy_n` are both 1 on the next clock, and `tgt_halt_n` never goes to 0 in that transaction.
- R9: While the initiator inserts wait clocks (`ini_rdy_n`=1, `ini_cyc_n`=0), `tgt_rdy_n` stays 0, no strobe is produced and no word is counted.
- R10: After a stop, a final phase with `ini_cyc_n`=1 and `ini_rdy_n`=0 is accepted with `tgt_sel_n`=0, `tgt_halt_n`=0, `tgt_rdy_n`=1 and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ini_cyc_n | input | 1 | Initiator transaction-active line, low while the initiator owns the bus for more phases |
| ini_rdy_n | input | 1 | Initiator ready, low when the initiator can complete the current phase |
| addr_hit | input | 1 | Address decode hit for this target, valid in the clock where the transaction starts |
| tgt_sel_n | output | 1 | Target select, low while this target owns the transaction |
| tgt_rdy_n | output | 1 | Target ready, low when this target can move a word |
| tgt_halt_n | output | 1 | Target stop request, low to end the burst |
| word_strobe | output | 1 | One-clock pulse per transferred word, for the local data path |

## Verification
The hardest case to reach is a stop that arrives while the initiator is stalling. In that case the initiator must notice the stop only on a wait clock and then present the last word with its cycle line already released. The bench reaches this case by sweeping burst lengths from one word up to beyond the limit and combining each length with zero, one or two wait clocks before every word. Some of these combinations put the stop on a wait clock, and others make the initiator's own end coincide exactly with the limit. A foreign transaction in which the decode-hit flag rises late checks that no claim happens part-way through.

// File: rtl/burst_target_pkg.sv
// Package: shared state encoding for the burst-limited target controller.
// Assumes: nothing beyond IEEE 1800-2017.
package burst_target_pkg;

    typedef enum logic [1:0] {
        TS_IDLE    = 2'd0,   // bus idle or between transactions
        TS_XFER    = 2'd1,   // claimed, moving words
        TS_DRAIN   = 2'd2,   // stop issued, waiting for the initiator to let go
        TS_FOREIGN = 2'd3    // another target's transaction is on the bus
    } tgt_state_e;

endpackage

// File: rtl/burst_word_counter.sv
// Module: counts words moved in the current transaction and flags the
// word after which the stop line must be armed.
// Assumes: clear and step are never high in the same clock (claim clock
// carries no transfer because target-ready is still off then).
module burst_word_counter #(
    parameter int BURST_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic arm_halt
);
    localparam int CW     = $clog2(BURST_MAX + 1);
    localparam bit ARM_EN = (BURST_MAX >= 2);
    localparam int ARM_AT = ARM_EN ? BURST_MAX - 2 : 0;

    logic [CW-1:0] count;

    // Word counter: cleared on claim, advanced per transferred word, saturates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (step && (count != CW'(BURST_MAX))) begin
            count <= count + 1'b1;
        end
    end

    // Arm flag: the word completing now is the one before the last allowed.
    always_comb begin
        arm_halt = ARM_EN && (count == CW'(ARM_AT));
    end

    // R5: never more words than the limit
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(BURST_MAX));

    // R5: no transfer is offered once the limit has been reached
    p_step_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (count < CW'(BURST_MAX)));

endmodule

// File: rtl/burst_target_fsm.sv
// Module: target handshake state machine. Claims on a decode hit, moves
// words, raises stop with ready on the last allowed word, and holds stop
// until the initiator releases both of its lines.
// Assumes: initiator follows the bus rules (ready held until completion,
// cycle line released only while ready is asserted). Outputs are registered
// and in positive logic; the top inverts them.
module burst_target_fsm
    import burst_target_pkg::*;
#(
    parameter int BURST_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ini_cyc_n,
    input  logic ini_rdy_n,
    input  logic addr_hit,
    input  logic arm_halt,
    output logic sel_q,
    output logic rdy_q,
    output logic halt_q,
    output logic claim,
    output logic xfer
);
    localparam bit HALT_AT_CLAIM = (BURST_MAX == 1);

    tgt_state_e state, state_d;
    logic       sel_d, rdy_d, halt_d;
    logic       bus_free;

    // Word moves when both ready lines are asserted.
    always_comb begin
        xfer     = !ini_rdy_n && rdy_q;
        bus_free = ini_cyc_n && ini_rdy_n;
    end

    // Next-state and next-output decision.
    always_comb begin
        state_d = state;
        sel_d   = sel_q;
        rdy_d   = rdy_q;
        halt_d  = halt_q;
        claim   = 1'b0;
        case (state)
            TS_IDLE: begin
                if (!ini_cyc_n) begin
                    if (addr_hit) begin
                        state_d = TS_XFER;
                        sel_d   = 1'b1;
                        rdy_d   = 1'b1;
                        halt_d  = HALT_AT_CLAIM;
                        claim   = 1'b1;
                    end else begin
                        state_d = TS_FOREIGN;
                    end
                end
            end
            TS_FOREIGN: begin
                if (bus_free) begin
                    state_d = TS_IDLE;
                end
            end
            TS_XFER: begin
                if (xfer) begin
                    if (halt_q) begin
                        state_d = TS_DRAIN;
                        rdy_d   = 1'b0;
                    end else if (ini_cyc_n) begin
                        state_d = TS_IDLE;
                        sel_d   = 1'b0;
                        rdy_d   = 1'b0;
                    end else if (arm_halt) begin
                        halt_d  = 1'b1;
                    end
                end else if (bus_free) begin
                    state_d = TS_IDLE;
                    sel_d   = 1'b0;
                    rdy_d   = 1'b0;
                    halt_d  = 1'b0;
                end
            end
            TS_DRAIN: begin
                if (bus_free) begin
                    state_d = TS_IDLE;
                    sel_d   = 1'b0;
                    halt_d  = 1'b0;
                end
            end
            default: begin
                state_d = TS_IDLE;
                sel_d   = 1'b0;
                rdy_d   = 1'b0;
                halt_d  = 1'b0;
            end
        endcase
    end

    // State and output registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= TS_IDLE;
            sel_q  <= 1'b0;
            rdy_q  <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            state  <= state_d;
            sel_q  <= sel_d;
            rdy_q  <= rdy_d;
            halt_q <= halt_d;
        end
    end

    // R2: a hit in idle claims the bus on the next clock
    p_claim_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_IDLE && !ini_cyc_n && addr_hit) |=> (sel_q && rdy_q));

    // R3: a miss in idle is never claimed
    p_no_foreign_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_FOREIGN) |=> !sel_q);

    // R5: stop first appears only alongside target-ready
    p_halt_with_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_q) |-> rdy_q);

    // R6: ready drops after a word moved under stop
    p_rdy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && halt_q) |=> !rdy_q);

    // R7: stop held while the initiator still owns a line
    p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !bus_free) |=> halt_q);

    // R7: stop and select are released together
    p_halt_sel_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt_q) |-> $fell(sel_q));

    // R8: an early end without stop releases select and ready
    p_early_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !halt_q && ini_cyc_n) |=> (!sel_q && !rdy_q && !halt_q));

    // R9: initiator wait keeps target-ready on
    p_wait_keeps_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_XFER && ini_rdy_n && !ini_cyc_n) |=> rdy_q);

    // R10: the extra final phase after stop keeps select and stop on
    p_drain_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_DRAIN && ini_cyc_n && !ini_rdy_n) |=> (sel_q && halt_q && !rdy_q));

endmodule

// File: rtl/burst_target_ctrl.sv
// Module: top of the burst-limited target handshake controller. Wires the
// state machine to the word counter and presents active-low bus lines.
// Assumes: addr_hit is valid in the clock where the transaction starts.
module burst_target_ctrl #(
    parameter int BURST_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ini_cyc_n,
    input  logic ini_rdy_n,
    input  logic addr_hit,
    output logic tgt_sel_n,
    output logic tgt_rdy_n,
    output logic tgt_halt_n,
    output logic word_strobe
);
    logic sel_q, rdy_q, halt_q;
    logic claim, xfer, arm_halt;

    burst_target_fsm #(.BURST_MAX(BURST_MAX)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ini_cyc_n (ini_cyc_n),
        .ini_rdy_n (ini_rdy_n),
        .addr_hit  (addr_hit),
        .arm_halt  (arm_halt),
        .sel_q     (sel_q),
        .rdy_q     (rdy_q),
        .halt_q    (halt_q),
        .claim     (claim),
        .xfer      (xfer)
    );

    burst_word_counter #(.BURST_MAX(BURST_MAX)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (claim),
        .step     (xfer),
        .arm_halt (arm_halt)
    );

    // Drive active-low bus lines and the per-word strobe.
    always_comb begin
        tgt_sel_n   = !sel_q;
        tgt_rdy_n   = !rdy_q;
        tgt_halt_n  = !halt_q;
        word_strobe = xfer;
    end

endmodule

// File: tb/tb_burst_target_ctrl.sv
`timescale 1ns/1ps
module tb_burst_target_ctrl;
    localparam int BM   = 4;
    localparam int HALF = 10;   // 50 MHz

    logic clk = 1'b0;
    logic rst_n;
    logic ini_cyc_n, ini_rdy_n, addr_hit;
    logic tgt_sel_n, tgt_rdy_n, tgt_halt_n, word_strobe;
    int   checks = 0;
    int   fails  = 0;

    always #HALF clk = ~clk;

    burst_target_ctrl #(.BURST_MAX(BM)) dut (
        .clk(clk), .rst_n(rst_n), .ini_cyc_n(ini_cyc_n), .ini_rdy_n(ini_rdy_n),
        .addr_hit(addr_hit), .tgt_sel_n(tgt_sel_n), .tgt_rdy_n(tgt_rdy_n),
        .tgt_halt_n(tgt_halt_n), .word_strobe(word_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Initiator model: wants n words, inserts w wait clocks before each word.
    task automatic run_burst(input int n, input int w);
        int  moved = 0, strobes = 0, left = n, wleft = w, guard = 0;
        int  bad_wait = 0, bad_rdy = 0, bad_ext = 0;
        bit  halt_seen = 0, after_halt = 0, fin = 0, waiting;
        int  exp_words = (n < BM) ? n : BM;
        bit  exp_halt  = (n >= BM);
        @(negedge clk); ini_cyc_n = 0; ini_rdy_n = 1; addr_hit = 1;
        @(negedge clk); addr_hit = 0;
        check(!tgt_sel_n == 1 && !tgt_rdy_n == 1, "R2 claim", {tgt_sel_n, tgt_rdy_n}, 0);
        while (!fin) begin
            if (wleft > 0 && !halt_seen) begin
                ini_rdy_n = 1; ini_cyc_n = 0; wleft--; waiting = 1;
            end else begin
                ini_rdy_n = 0; ini_cyc_n = (left <= 1 || halt_seen) ? 1'b1 : 1'b0; waiting = 0;
            end
            #(HALF - 2);
            if (waiting && (tgt_rdy_n !== 1'b0 || word_strobe !== 1'b0)) bad_wait++;
            if (word_strobe) strobes++;
            if (after_halt && tgt_rdy_n == 1'b0) bad_rdy++;
            if (!ini_rdy_n && (!tgt_rdy_n || !tgt_halt_n)) begin
                if (!tgt_rdy_n) begin
                    moved++; left--; wleft = w;
                    if (!tgt_halt_n) after_halt = 1;
                end else if (tgt_sel_n || word_strobe) begin
                    bad_ext++;
                end
                if (ini_cyc_n) fin = 1;
            end
            if (!tgt_halt_n) halt_seen = 1;
            @(negedge clk);
            guard++;
            if (guard > 60) fin = 1;
        end
        ini_cyc_n = 1; ini_rdy_n = 1;
        if (exp_halt) begin
            check(tgt_halt_n == 0 && tgt_sel_n == 0, "R7 stop held", {tgt_halt_n, tgt_sel_n}, 0);
            check(tgt_rdy_n == 1, "R6 ready off after stop", tgt_rdy_n, 1);
        end else begin
            check(tgt_sel_n == 1 && tgt_rdy_n == 1, "R8 early release", {tgt_sel_n, tgt_rdy_n}, 3);
        end
        @(negedge clk);
        check({tgt_sel_n, tgt_rdy_n, tgt_halt_n} == 3'b111, "R7 idle after release",
              {tgt_sel_n, tgt_rdy_n, tgt_halt_n}, 7);
        check(moved == exp_words, "R5 words moved", moved, exp_words);
        check(strobes == exp_words, "R4 strobe count", strobes, exp_words);
        check(halt_seen == exp_halt, exp_halt ? "R5 stop used" : "R8 no stop", halt_seen, exp_halt);
        check(bad_wait == 0, "R9 wait clocks", bad_wait, 0);
        check(bad_rdy == 0, "R6 ready stays off", bad_rdy, 0);
        check(bad_ext == 0, "R10 extra phase", bad_ext, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; ini_cyc_n = 1; ini_rdy_n = 0; addr_hit = 1;
        repeat (3) @(negedge clk);
        check({tgt_sel_n, tgt_rdy_n, tgt_halt_n} == 3'b111, "R1 reset lines",
              {tgt_sel_n, tgt_rdy_n, tgt_halt_n}, 7);
        check(word_strobe == 0, "R1 reset strobe", word_strobe, 0);
        ini_rdy_n = 1; addr_hit = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);

        // R3: foreign transaction, hit rising late must not claim
        ini_cyc_n = 0; addr_hit = 0;
        @(negedge clk); ini_rdy_n = 0; addr_hit = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(tgt_sel_n == 1 && tgt_rdy_n == 1, "R3 no late claim", {tgt_sel_n, tgt_rdy_n}, 3);
        end
        ini_cyc_n = 1; addr_hit = 0;
        @(negedge clk); ini_rdy_n = 1;
        @(negedge clk);
        check(tgt_sel_n == 1, "R3 still unclaimed", tgt_sel_n, 1);

        // Sweep burst length and wait insertion
        for (int w = 0; w <= 2; w++) begin
            for (int n = 1; n <= BM + 3; n++) begin
                run_burst(n, w);
            end
        end

        // Back-to-back long bursts (R5 strobe equals limit)
        run_burst(BM + 5, 0);
        run_burst(BM + 1, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule